// File: doc/BRIEF.md
# Fault-Priority Status Sampler

This block moves an already filtered fault indication onto a slow, periodically sampled status path and presents the result as an active-low status pin. A sampling strobe arrives once every `SAMPLE_PERIOD` clock cycles. Any signal shorter than that period could fall between two strobes and be lost.

To keep faults from being lost, every rising edge of the fault input starts a hold window of `SAMPLE_PERIOD + 1` cycles. The conditioned signal stays asserted for that whole window. Falling edges, which mean recovery, get no such help. A recovery shorter than one strobe period can therefore go unseen. This is intended: an onset of fault always wins over a recovery.

The sample register takes the conditioned value only in strobe cycles. The status pin is the inverse of that register. A high level on the pin stands for the released (high-impedance) state of an open-drain output. The strobe is a plain periodic enable pulse, and every pin is a control or status level, so the block has no valid/ready handshake.

Top module: `fault_status_sampler`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `fault_n_o` is 1 and no hold window is active.
- R2: The sample register, and so `fault_n_o`, changes only on the clock edge that ends a cycle in which `sample_stb_i` is 1.
- R3: A rising edge of `fault_i` (0 in the previous cycle, 1 now) keeps the conditioned fault asserted for exactly `SAMPLE_PERIOD + 1` cycles, counting the edge cycle, whatever `fault_i` does afterwards. A strobe in the last of those cycles captures a fault, and a strobe in the cycle after them does not.
- R4: A falling edge of `fault_i` is not extended. Once the hold window has ended, the conditioned fault is 0 in the same cycle in which `fault_i` is 0. A strobe in that cycle releases `fault_n_o` at the next edge.
- R5: A new rising edge during an active hold window restarts the window with its full length of `SAMPLE_PERIOD + 1` cycles, counted from the new edge.
- R6: After a strobe, `fault_n_o` is 0 if the conditioned fault was 1 in the strobe cycle, and 1 if it was 0.
- R7: A fault pulse of a single cycle is always reported by the next strobe, provided strobes come every `SAMPLE_PERIOD` cycles.
- R8: A recovery that returns to fault before the next strobe goes unreported: `fault_n_o` stays 0 through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_i | input | 1 | Filtered fault level, 1 = fault |
| sample_stb_i | input | 1 | Periodic one-cycle sampling strobe |
| fault_n_o | output | 1 | Sampled fault status, 0 = fault, 1 = released |

## Verification
The bench aims at the exact edge of the hold window. It places a strobe in the last held cycle and another one cycle later. A window that is one cycle short would miss the first strobe, and one that is one cycle long would catch the second. A fault edge is re-raised late in a window with the strobe placed after the original window would have ended. A design that does not reload would release the pin there. The bench also checks that recovery gets no stretch: a stretched recovery would keep the pin low for one strobe too long. A brief dip in the fault, and a fault held with no strobe, must leave the pin unchanged. A design that samples outside the strobe, or lets recovery win, would toggle the pin in those cases.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic {
    FPS_CLEAR = 1'b0,
    FPS_FAULT = 1'b1
  } fps_state_e;

  function automatic int unsigned fps_cnt_width(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len);
  endfunction
endpackage

// File: rtl/fps_rise_detect.sv
module fps_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/fps_stretcher.sv
module fps_stretcher #(
  parameter int unsigned HOLD_LEN = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic rise_i,
  output logic cond_o,
  output logic [fps_pkg::fps_cnt_width(HOLD_LEN)-1:0] cnt_o
);
  localparam int unsigned CW = fps_pkg::fps_cnt_width(HOLD_LEN);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          hold_act;

  assign hold_act = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (rise_i)   cnt_q <= LOAD;
    else if (hold_act) cnt_q <= cnt_q - 1'b1;
  end

  assign cond_o = level_i | hold_act;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fps_sample_reg.sv
module fps_sample_reg
  import fps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb_i,
  input  logic       cond_i,
  output fps_state_e state_o
);
  fps_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= FPS_CLEAR;
    else if (stb_i) state_q <= cond_i ? FPS_FAULT : FPS_CLEAR;
  end

  assign state_o = state_q;
endmodule

// File: rtl/fault_status_sampler.sv
module fault_status_sampler
  import fps_pkg::*;
#(
  parameter int unsigned SAMPLE_PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic sample_stb_i,
  output logic fault_n_o
);
  localparam int unsigned HOLD_LEN = SAMPLE_PERIOD + 1;
  localparam int unsigned CW       = fps_cnt_width(HOLD_LEN);

  logic          rise_w;
  logic          cond_w;
  logic [CW-1:0] cnt_w;
  fps_state_e    state_w;

  fps_rise_detect u_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (fault_i),
    .rise_o  (rise_w)
  );

  fps_stretcher #(.HOLD_LEN(HOLD_LEN)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (fault_i),
    .rise_i  (rise_w),
    .cond_o  (cond_w),
    .cnt_o   (cnt_w)
  );

  fps_sample_reg u_samp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb_i   (sample_stb_i),
    .cond_i  (cond_w),
    .state_o (state_w)
  );

  assign fault_n_o = (state_w == FPS_FAULT) ? 1'b0 : 1'b1;
endmodule

// File: rtl/fault_status_sampler_chk.sv
module fault_status_sampler_chk #(
  parameter int unsigned SAMPLE_PERIOD = 8,
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_i,
  input logic          sample_stb_i,
  input logic          fault_n_o,
  input logic          cond_w,
  input logic [CW-1:0] cnt_w
);
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb_i |=> $stable(fault_n_o)); // R2
  AST_STB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb_i |=> (fault_n_o == !$past(cond_w))); // R6
  AST_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_i) |=> cond_w); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= CW'(SAMPLE_PERIOD)); // R3
  AST_FALL_UNEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_i && $past(!fault_i) && ($past(cnt_w) <= 1)) |-> !cond_w); // R4
  AST_RESET_REL: assert property (@(posedge clk)
    !rst_n |=> fault_n_o); // R1
endmodule

bind fault_status_sampler fault_status_sampler_chk #(
  .SAMPLE_PERIOD (SAMPLE_PERIOD),
  .CW            (CW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fault_i      (fault_i),
  .sample_stb_i (sample_stb_i),
  .fault_n_o    (fault_n_o),
  .cond_w       (cond_w),
  .cnt_w        (cnt_w)
);

// File: tb/fault_status_sampler_tb_top.sv
module fault_status_sampler_tb_top;
  localparam int unsigned P = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_i = 1'b0;
  logic sample_stb_i = 1'b0;
  logic fault_n_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fault_status_sampler #(.SAMPLE_PERIOD(P)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_i      (fault_i),
    .sample_stb_i (sample_stb_i),
    .fault_n_o    (fault_n_o)
  );

  task automatic check(input logic exp, input string req, input string what);
    n_chk++;
    if (fault_n_o !== exp) begin
      n_bad++;
      $display("FAIL %s %s: fault_n_o=%b expected %b", req, what, fault_n_o, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic tick(input logic f, input logic s);
    fault_i = f;
    sample_stb_i = s;
    @(negedge clk);
  endtask

  task automatic clear_state();
    for (int i = 0; i < P + 3; i++) tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check(1'b1, "R1", "during reset");
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b0, 1'b0);
    check(1'b1, "R1", "first cycle after reset");
    tick(1'b0, 1'b1);
    check(1'b1, "R1", "strobe with idle input after reset");
  endtask

  task automatic t_no_strobe();
    clear_state();
    for (int i = 0; i < 2 * P; i++) begin
      tick(1'b1, 1'b0);
      check(1'b1, "R2", "fault held without strobe");
    end
    tick(1'b1, 1'b1);
    check(1'b0, "R2", "strobe captures held fault");
    tick(1'b0, 1'b0);
    check(1'b0, "R2", "no strobe after recovery");
  endtask

  task automatic t_pulse_last_cycle();
    clear_state();
    tick(1'b1, 1'b0);
    for (int i = 1; i < P; i++) begin
      tick(1'b0, 1'b0);
      check(1'b1, "R2", "pulse held, no strobe yet");
    end
    tick(1'b0, 1'b1);
    check(1'b0, "R7", "one-cycle pulse caught in last held cycle");
    tick(1'b0, 1'b1);
    check(1'b1, "R3", "window ended after P+1 cycles");
  endtask

  task automatic t_pulse_after_window();
    clear_state();
    tick(1'b1, 1'b0);
    for (int i = 1; i <= P; i++) tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    check(1'b1, "R3", "strobe one cycle past window");
  endtask

  task automatic t_reload();
    clear_state();
    tick(1'b1, 1'b0);
    for (int i = 1; i < 5; i++) tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    for (int i = 6; i < 5 + P; i++) tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    check(1'b0, "R5", "reloaded window still held");
    tick(1'b0, 1'b1);
    check(1'b1, "R5", "reloaded window ended");
  endtask

  task automatic t_recovery_unstretched();
    clear_state();
    for (int i = 0; i < P + 3; i++) tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    check(1'b0, "R6", "sampled fault drives pin low");
    tick(1'b0, 1'b1);
    check(1'b1, "R4", "recovery sampled in its first cycle");
  endtask

  task automatic t_short_recovery();
    clear_state();
    for (int i = 0; i < P + 3; i++) tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    check(1'b0, "R6", "fault sampled before dip");
    tick(1'b0, 1'b0);
    check(1'b0, "R8", "dip cycle 1");
    tick(1'b0, 1'b0);
    check(1'b0, "R8", "dip cycle 2");
    tick(1'b1, 1'b1);
    check(1'b0, "R8", "dip lost at strobe");
    tick(1'b0, 1'b1);
    check(1'b0, "R8", "new onset held over recovery");
  endtask

  initial begin
    t_reset();
    t_no_strobe();
    t_pulse_last_cycle();
    t_pulse_after_window();
    t_reload();
    t_recovery_unstretched();
    t_short_recovery();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule